// File: doc/BRIEF.md
# Toggle-Acknowledged Error Interrupt Unit

This block keeps a global error status word and a matching acknowledge word that together form a toggle handshake. Hardware signals a new error by inverting a status bit instead of setting it. A bit is outstanding while the status bit and the acknowledge bit disagree. Software retires a bit by copying its status value into the acknowledge word. The block also owns the wired interrupt outputs for four request sources: event queue, page request, command-sync completion and global error. Every output is an edge-style pulse that lasts one clock cycle.

On the hardware side there is a request strobe, a two-bit source code and a per-bit error mask. The mask is used only for global-error requests. On the software side there is a single write port that targets either the acknowledge word or the interrupt-enable control word, and a combinational read port. The read port returns the status, acknowledge, control or outstanding-error word. A sticky flag records any acknowledge write that inverted a bit that was not outstanding. Such a write is still applied in full.

Top module: `fault_toggle_irq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the status, acknowledge and control words read zero, all four pulse outputs are low and the misuse flag is low.
- R2: The outstanding word (read select 3) always equals status XOR acknowledge.
- R3: A global-error request (source code 3) inverts exactly the status bits that are set in the mask and not outstanding. All other status bits keep their value. Without such a request the status word does not change.
- R4: A global-error request whose mask has no bit outside the outstanding set leaves the status word unchanged and produces no pulse.
- R5: The global-error pulse rises in the cycle after a global-error request only when at least one bit was newly inverted and control bit 0 is set.
- R6: An event-queue request (source code 0) gives a pulse on the event-queue line in the next cycle only when control bit 2 is set.
- R7: A command-sync request (source code 2) always gives a pulse on its line in the next cycle, whatever the control word holds.
- R8: A page request (source code 1) never produces a pulse.
- R9: Each accepted request gives a pulse of exactly one cycle. Its output is low in the following cycle unless a new request of the same source arrives in that cycle.
- R10: A write to the acknowledge word (write select 0) stores the written value unchanged, including bits that were not outstanding.
- R11: An acknowledge write that inverts any non-outstanding bit sets the misuse flag. The flag stays set until reset.
- R12: When a global-error request and an acknowledge write arrive in the same cycle, the newly inverted bits are computed from the acknowledge value before the write, and both updates take effect together.
- R13: A control write (write select 1) keeps only bits 0 and 2. All other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req_valid | input | 1 | Interrupt request strobe, one request per cycle |
| hw_req_src | input | 2 | Source: 0 event queue, 1 page request, 2 command sync, 3 global error |
| hw_err_mask | input | 32 | Error bits to raise on a global-error request |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 1 | Write target: 0 acknowledge word, 1 control word |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_sel | input | 2 | Read select: 0 status, 1 acknowledge, 2 control, 3 outstanding |
| sw_rd_data | output | 32 | Combinational read data |
| irq_evq | output | 1 | Event-queue interrupt pulse |
| irq_page | output | 1 | Page-request interrupt pulse (never fires) |
| irq_sync | output | 1 | Command-sync interrupt pulse |
| irq_err | output | 1 | Global-error interrupt pulse |
| ack_misuse | output | 1 | Sticky flag for acknowledge writes that invert non-outstanding bits |

## Verification
The assertions assume that the inputs are stable around each rising edge, that at most one request arrives per cycle, and that the mask matters only when the source code is 3. The source code and mask may be arbitrary on other requests. The stimulus changes every input on the falling edge. It never needs more than one request per cycle, because the port offers only one. Mask and write data are given explicit values even on cycles where they are ignored, so no property sees an unknown value.

// File: rtl/fault_toggle_pkg.sv
package fault_toggle_pkg;

  typedef enum logic [1:0] {
    SRC_EVQ  = 2'd0,
    SRC_PAGE = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_ERR  = 2'd3
  } irq_src_e;

  typedef enum logic [1:0] {
    RD_STATUS  = 2'd0,
    RD_ACK     = 2'd1,
    RD_CTRL    = 2'd2,
    RD_PENDING = 2'd3
  } rd_sel_e;

  localparam int unsigned NUM_SRC     = 4;
  localparam int unsigned CTRL_ERR_EN = 0;
  localparam int unsigned CTRL_EVQ_EN = 2;

endpackage

// File: rtl/fault_err_bank.sv
module fault_err_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raise_req,
  input  logic [W-1:0] raise_mask,
  input  logic         ack_we,
  input  logic [W-1:0] ack_wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] ack_q,
  output logic [W-1:0] pending,
  output logic         raised_any,
  output logic         misuse_evt
);

  logic [W-1:0] fresh_bits;
  logic [W-1:0] status_d;
  logic [W-1:0] ack_d;
  logic [W-1:0] ack_flips;

  // Both updates are computed from the values held before this edge.
  always_comb begin
    pending    = status_q ^ ack_q;
    fresh_bits = raise_mask & ~pending;
    raised_any = raise_req && (fresh_bits != '0);
    status_d   = status_q;
    if (raise_req) begin
      status_d = status_q ^ fresh_bits;
    end
    ack_d      = ack_q;
    ack_flips  = '0;
    if (ack_we) begin
      ack_d     = ack_wdata;
      ack_flips = ack_q ^ ack_wdata;
    end
    misuse_evt = ack_we && ((ack_flips & ~pending) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ack_q    <= '0;
    end else begin
      if (raise_req) begin
        status_q <= status_d;
      end
      if (ack_we) begin
        ack_q <= ack_d;
      end
    end
  end

  // R10: the acknowledge word takes the written value unchanged.
  p_ack_verbatim_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (ack_q == $past(ack_wdata)));

  // R4: a request that brings nothing new leaves the status word alone.
  p_no_fresh_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_req && ((raise_mask & ~pending) == '0)) |=> $stable(status_q));

  // R3: bits outside the mask never change.
  p_mask_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raise_req |=> (((status_q ^ $past(status_q)) & ~$past(raise_mask)) == '0));

  // R3: without a request the status word is held.
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_req |=> $stable(status_q));

  // R3: an outstanding bit is never inverted by hardware.
  p_pending_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raise_req |=> (((status_q ^ $past(status_q)) & $past(pending)) == '0));

endmodule

// File: rtl/fault_ctrl_reg.sv
module fault_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [W-1:0] ctrl_wdata,
  output logic [W-1:0] ctrl_q,
  output logic         err_en,
  output logic         evq_en
);
  import fault_toggle_pkg::*;

  localparam logic [W-1:0] KEEP_MASK =
    (W'(1) << CTRL_ERR_EN) | (W'(1) << CTRL_EVQ_EN);

  logic [W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign err_en = ctrl_q[CTRL_ERR_EN];
  assign evq_en = ctrl_q[CTRL_EVQ_EN];

  // R13: the control word changes only on a write.
  p_ctrl_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

  // R13: after a write only the two enable bits may be set.
  p_ctrl_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ((ctrl_q & ~KEEP_MASK) == '0));

endmodule

// File: rtl/fault_pulse_gen.sv
module fault_pulse_gen #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse_q
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic line_d;

    always_comb begin
      line_d = fire[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q[i] <= 1'b0;
      end else begin
        pulse_q[i] <= line_d;
      end
    end

    // R9: a line is high only in the cycle after a fire.
    p_pulse_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fire[i] |=> !pulse_q[i]);
  end

endmodule

// File: rtl/fault_toggle_irq.sv
module fault_toggle_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_req_valid,
  input  logic [1:0]   hw_req_src,
  input  logic [W-1:0] hw_err_mask,
  input  logic         sw_wr_en,
  input  logic         sw_wr_sel,
  input  logic [W-1:0] sw_wr_data,
  input  logic [1:0]   sw_rd_sel,
  output logic [W-1:0] sw_rd_data,
  output logic         irq_evq,
  output logic         irq_page,
  output logic         irq_sync,
  output logic         irq_err,
  output logic         ack_misuse
);
  import fault_toggle_pkg::*;

  logic [W-1:0] status_q;
  logic [W-1:0] ack_q;
  logic [W-1:0] pending;
  logic [W-1:0] ctrl_q;
  logic         raised_any;
  logic         misuse_evt;
  logic         err_en;
  logic         evq_en;
  logic         raise_req;
  logic         ack_we;
  logic         ctrl_we;
  logic [NUM_SRC-1:0] fire;
  logic [NUM_SRC-1:0] pulse_q;
  logic         flag_d;
  logic         flag_q;
  irq_src_e     src;

  always_comb begin
    src       = irq_src_e'(hw_req_src);
    raise_req = hw_req_valid && (src == SRC_ERR);
    ack_we    = sw_wr_en && !sw_wr_sel;
    ctrl_we   = sw_wr_en && sw_wr_sel;
  end

  fault_err_bank #(.W(W)) u_err_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_req  (raise_req),
    .raise_mask (hw_err_mask),
    .ack_we     (ack_we),
    .ack_wdata  (sw_wr_data),
    .status_q   (status_q),
    .ack_q      (ack_q),
    .pending    (pending),
    .raised_any (raised_any),
    .misuse_evt (misuse_evt)
  );

  fault_ctrl_reg #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (sw_wr_data),
    .ctrl_q     (ctrl_q),
    .err_en     (err_en),
    .evq_en     (evq_en)
  );

  // Request decode into per-source fire strobes; page requests never fire.
  always_comb begin
    fire = '0;
    if (hw_req_valid) begin
      unique case (src)
        SRC_EVQ:  fire[SRC_EVQ]  = evq_en;
        SRC_PAGE: fire[SRC_PAGE] = 1'b0;
        SRC_SYNC: fire[SRC_SYNC] = 1'b1;
        SRC_ERR:  fire[SRC_ERR]  = raised_any && err_en;
        default:  fire = '0;
      endcase
    end
  end

  fault_pulse_gen #(.N(NUM_SRC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .pulse_q (pulse_q)
  );

  assign irq_evq  = pulse_q[SRC_EVQ];
  assign irq_page = pulse_q[SRC_PAGE];
  assign irq_sync = pulse_q[SRC_SYNC];
  assign irq_err  = pulse_q[SRC_ERR];

  always_comb begin
    flag_d = flag_q | misuse_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign ack_misuse = flag_q;

  always_comb begin
    unique case (rd_sel_e'(sw_rd_sel))
      RD_STATUS:  sw_rd_data = status_q;
      RD_ACK:     sw_rd_data = ack_q;
      RD_CTRL:    sw_rd_data = ctrl_q;
      RD_PENDING: sw_rd_data = pending;
      default:    sw_rd_data = '0;
    endcase
  end

  // R7: command sync always pulses.
  p_sync_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_valid && hw_req_src == 2'd2) |=> irq_sync);

  // R6: event-queue pulse is gated by the enable.
  p_evq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_valid && hw_req_src == 2'd0) |=> (irq_evq == $past(ctrl_q[2])));

  // R5: a disabled global-error request never pulses.
  p_err_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_valid && hw_req_src == 2'd3 && !ctrl_q[0]) |=> !irq_err);

  // R5: the global-error pulse implies the status word changed.
  p_err_changed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (status_q != $past(status_q)));

  // R8: page requests stay silent.
  p_page_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req_valid && hw_req_src == 2'd1) |=> !irq_page);

  // R11: the misuse flag is sticky.
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_misuse |=> ack_misuse);

  // R9: at most one pulse per cycle, since one request per cycle.
  p_one_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_evq, irq_page, irq_sync, irq_err}));

endmodule

// File: tb/fault_toggle_irq_bench.sv
`timescale 1ns/1ps
module fault_toggle_irq_bench;

  typedef struct packed {
    logic        req;
    logic [1:0]  src;
    logic [31:0] mask;
    logic        wr;
    logic        wsel;
    logic [31:0] wdata;
    logic [31:0] e_stat;
    logic [31:0] e_ack;
    logic [31:0] e_ctrl;
    logic [3:0]  e_irq;   // {err, sync, page, evq}
    logic        e_flag;
    logic [3:0]  rq;      // requirement number named in messages
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R13 enable both
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b1, 32'h5,        32'h0,        32'h0,  32'h5, 4'b0000, 1'b0, 4'd13},
    // R3/R5 first raise
    '{1'b1, 2'd3, 32'h3,        1'b0, 1'b0, 32'h0,        32'h3,        32'h0,  32'h5, 4'b1000, 1'b0, 4'd3},
    // R3 partial overlap with outstanding
    '{1'b1, 2'd3, 32'h6,        1'b0, 1'b0, 32'h0,        32'h7,        32'h0,  32'h5, 4'b1000, 1'b0, 4'd3},
    // R4 nothing new
    '{1'b1, 2'd3, 32'h5,        1'b0, 1'b0, 32'h0,        32'h7,        32'h0,  32'h5, 4'b0000, 1'b0, 4'd4},
    // R10 legal ack
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h1,        32'h7,        32'h1,  32'h5, 4'b0000, 1'b0, 4'd10},
    // R3 re-raise after ack
    '{1'b1, 2'd3, 32'h1,        1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h5, 4'b1000, 1'b0, 4'd3},
    // R6 evq enabled
    '{1'b1, 2'd0, 32'hFFFF,     1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h5, 4'b0001, 1'b0, 4'd6},
    // R7 sync
    '{1'b1, 2'd2, 32'hFFFF,     1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h5, 4'b0100, 1'b0, 4'd7},
    // R8 page silent
    '{1'b1, 2'd1, 32'hFFFF,     1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h5, 4'b0000, 1'b0, 4'd8},
    // R13 disable all
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b1, 32'h0,        32'h6,        32'h1,  32'h0, 4'b0000, 1'b0, 4'd13},
    // R6 evq disabled
    '{1'b1, 2'd0, 32'h0,        1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h0, 4'b0000, 1'b0, 4'd6},
    // R7 sync ignores enables
    '{1'b1, 2'd2, 32'h0,        1'b0, 1'b0, 32'h0,        32'h6,        32'h1,  32'h0, 4'b0100, 1'b0, 4'd7},
    // R5 raise while disabled: status changes, no pulse
    '{1'b1, 2'd3, 32'h100,      1'b0, 1'b0, 32'h0,        32'h106,      32'h1,  32'h0, 4'b0000, 1'b0, 4'd5},
    // R12 raise and ack together
    '{1'b1, 2'd3, 32'h18,       1'b1, 1'b0, 32'h7,        32'h11E,      32'h7,  32'h0, 4'b0000, 1'b0, 4'd12},
    // R11 ack toggles a non-outstanding bit
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h27,       32'h11E,      32'h27, 32'h0, 4'b0000, 1'b1, 4'd11},
    // R11 flag sticky
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b0, 32'h27,       32'h11E,      32'h27, 32'h0, 4'b0000, 1'b1, 4'd11},
    // R13 reserved bits dropped
    '{1'b0, 2'd0, 32'h0,        1'b1, 1'b1, 32'hFFFFFFFF, 32'h11E,      32'h27, 32'h5, 4'b0000, 1'b1, 4'd13},
    // R4 enabled but mask fully outstanding
    '{1'b1, 2'd3, 32'h20,       1'b0, 1'b0, 32'h0,        32'h11E,      32'h27, 32'h5, 4'b0000, 1'b1, 4'd4},
    // R5 top bit raise
    '{1'b1, 2'd3, 32'h80000000, 1'b0, 1'b0, 32'h0,        32'h8000011E, 32'h27, 32'h5, 4'b1000, 1'b1, 4'd5}
  };

  logic        clk;
  logic        rst_n;
  logic        hw_req_valid;
  logic [1:0]  hw_req_src;
  logic [31:0] hw_err_mask;
  logic        sw_wr_en;
  logic        sw_wr_sel;
  logic [31:0] sw_wr_data;
  logic [1:0]  sw_rd_sel;
  logic [31:0] sw_rd_data;
  logic        irq_evq, irq_page, irq_sync, irq_err, ack_misuse;

  int checks;
  int failures;
  bit done;

  fault_toggle_irq u_fault_toggle_irq (
    .clk(clk), .rst_n(rst_n),
    .hw_req_valid(hw_req_valid), .hw_req_src(hw_req_src), .hw_err_mask(hw_err_mask),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .sw_rd_sel(sw_rd_sel), .sw_rd_data(sw_rd_data),
    .irq_evq(irq_evq), .irq_page(irq_page), .irq_sync(irq_sync), .irq_err(irq_err),
    .ack_misuse(ack_misuse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic read_word(input logic [1:0] sel, output logic [31:0] val);
    sw_rd_sel = sel;
    #0.2;
    val = sw_rd_data;
  endtask

  task automatic check_state(input string rq, input logic [31:0] es, input logic [31:0] ea,
                             input logic [31:0] ec, input logic [3:0] ei, input logic ef);
    logic [31:0] v;
    read_word(2'd0, v); check(rq, "status", v, es);
    read_word(2'd1, v); check(rq, "ack", v, ea);
    read_word(2'd2, v); check(rq, "ctrl", v, ec);
    read_word(2'd3, v); check("R2", "pending", v, es ^ ea);
    check(rq, "irq", {28'd0, irq_err, irq_sync, irq_page, irq_evq}, {28'd0, ei});
    check(rq, "flag", {31'd0, ack_misuse}, {31'd0, ef});
  endtask

  task automatic idle_inputs();
    hw_req_valid = 1'b0; hw_req_src = 2'd0; hw_err_mask = '0;
    sw_wr_en = 1'b0; sw_wr_sel = 1'b0; sw_wr_data = '0;
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; sw_rd_sel = 2'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check_state("R1", 32'h0, 32'h0, 32'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 32'h0, 32'h0, 32'h0, 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      hw_req_valid = VECS[i].req;  hw_req_src = VECS[i].src;  hw_err_mask = VECS[i].mask;
      sw_wr_en = VECS[i].wr;       sw_wr_sel = VECS[i].wsel;  sw_wr_data = VECS[i].wdata;
      @(negedge clk);
      idle_inputs();
      check_state($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].e_stat, VECS[i].e_ack,
                  VECS[i].e_ctrl, VECS[i].e_irq, VECS[i].e_flag);
      @(negedge clk);
      // R9: pulse gone one cycle later
      check("R9", $sformatf("irq after vec%0d", i),
            {28'd0, irq_err, irq_sync, irq_page, irq_evq}, 32'h0);
    end

    // R9: back-to-back sync requests give a pulse each cycle, then drop
    hw_req_valid = 1'b1; hw_req_src = 2'd2;
    @(negedge clk);
    check("R9", "sync b2b 1", {31'd0, irq_sync}, 32'h1);
    @(negedge clk);
    check("R9", "sync b2b 2", {31'd0, irq_sync}, 32'h1);
    idle_inputs();
    @(negedge clk);
    check("R9", "sync b2b drop", {31'd0, irq_sync}, 32'h0);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_state("R1", 32'h0, 32'h0, 32'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: enable off after reset, raise gives status but no pulse
    hw_req_valid = 1'b1; hw_req_src = 2'd3; hw_err_mask = 32'h1;
    @(negedge clk);
    idle_inputs();
    check_state("R5", 32'h1, 32'h0, 32'h0, 4'b0000, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule